// File: doc/BRIEF.md
# Two-stage CRC-32 engine

This block produces the CRC-32 of a message delivered one byte per clock on a valid/last stream. It splits the division into two stages. The first stage keeps a 123-bit remainder modulo a sparse polynomial P(x) = x^123 + x^111 + x^92 + x^84 + x^64 + x^46 + x^23 + 1. P(x) is an exact multiple of the CRC-32 generator. Its nonzero exponents lie at least eight apart, so absorbing one byte costs at most one two-input XOR per remainder bit. The second stage runs once per message, after the last byte. It folds the wide remainder down to 32 bits modulo the true generator, one byte per cycle, over 16 cycles. The input reports not-ready while this happens.

The all-ones starting value is handled without touching the data path. The sparse register is preloaded with a 32-bit constant h, chosen so that x^32·h ≡ 0xFFFFFFFF mod G(x). This amounts to a virtual header placed before the message, so messages shorter than four bytes are also correct. The published result is the bitwise complement of the folded remainder.

A small controller sequences the work through four states. IDLE is entered at reset. ACCUM means a message is open. FOLD is the 16-cycle reduction. DONE means the result is published. The transitions are: IDLE or DONE to ACCUM on a non-final byte; IDLE, DONE or ACCUM to FOLD on the final byte; ACCUM to ACCUM on a non-final byte; FOLD to DONE when the fold stage signals its last step. A new message may start in DONE.

Top module: `crc32_twostep`

## Requirements
- R1: While reset is held and in the first cycle after it is released, crc_done is 0 and in_ready is 1.
- R2: A byte is taken on each rising edge at which in_valid and in_ready are both 1. Bit 7 of a byte is the highest-order bit of that byte, and earlier bytes are of higher order. The byte taken with in_last = 1 ends the message. Cycles with in_valid = 0 between bytes have no effect on the result.
- R3: For a message M(x) of n bytes, crc_out equals the bitwise NOT of ((0xFFFFFFFF·x^(8n) + x^32·M(x)) mod G(x)), where G(x) is x^32 plus the terms of 0x04C11DB7. No bit reflection is applied. The nine ASCII bytes "123456789" give 0xFC891918.
- R4: Leading zero bytes change the result. For example, {0x00,0x00,0x5A} and {0x5A} give different values.
- R5: After the edge that takes a final byte, in_ready is 0 for the next 16 cycles. crc_done rises on the 16th rising edge after that edge.
- R6: A byte offered while in_ready is 0 is not taken. It changes neither the pending result nor the result of the next message.
- R7: Once crc_done is 1, it stays 1 and crc_out stays unchanged until a byte is taken. crc_done is 0 from the edge that takes that byte.
- R8: The result is correct for every one-byte message and for messages of 2, 3 and up to 40 bytes. This includes lengths shorter than the 32-bit CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | The offered byte is the final byte of its message |
| in_ready | output | 1 | Bytes are accepted this cycle (0 during the fold) |
| crc_out | output | 32 | Complemented CRC-32 of the last completed message |
| crc_done | output | 1 | crc_out holds a finished result |

## Verification
The hardest situation to reach from the ports is a byte offered during the 16-cycle fold. Such a byte must leave both the sparse remainder and the fold untouched. The stimulus holds in_valid high with a final-marked byte throughout one fold and drops it just before the fold ends. The bench then checks both that result and the next message's result against a bit-serial model. Back-to-back messages that start in the same cycle crc_done is high, together with one- to three-byte messages, exercise the preloaded header path where the initial value is not inside the message.

// File: rtl/crc2s_pkg.sv
package crc2s_pkg;

    localparam int          DATA_W   = 8;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
    localparam int          SPR_W    = 123;

    // low-order terms of the sparse multiple of the CRC-32 generator
    localparam logic [SPR_W-1:0] SPR_TAPS =
        (123'd1 << 111) | (123'd1 << 92) | (123'd1 << 84) | (123'd1 << 64) |
        (123'd1 << 46)  | (123'd1 << 23) | 123'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_FOLD,
        ST_DONE
    } crc2s_state_e;

endpackage

// File: rtl/crc2s_ctrl.sv
module crc2s_ctrl
    import crc2s_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid_i,
    input  logic in_last_i,
    input  logic fin_i,
    output logic ready_o,
    output logic done_o,
    output logic acc_o,
    output logic close_o
);

    crc2s_state_e st_q;
    crc2s_state_e st_d;

    assign acc_o   = in_valid_i && ready_o;
    assign close_o = acc_o && in_last_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_ACCUM, ST_DONE: begin
                if (acc_o) st_d = in_last_i ? ST_FOLD : ST_ACCUM;
            end
            ST_FOLD: begin
                if (fin_i) st_d = ST_DONE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        ready_o = 1'b1;
        done_o  = 1'b0;
        unique case (st_q)
            ST_FOLD: ready_o = 1'b0;
            ST_DONE: done_o  = 1'b1;
            default: ;
        endcase
    end

    // R2
    close_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> !ready_o);

    // R5
    fold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FOLD && !fin_i) |=> (st_q == ST_FOLD));

endmodule

// File: rtl/crc2s_sparse_div.sv
module crc2s_sparse_div #(
    parameter int               SPR_W   = 123,
    parameter int               DATA_W  = 8,
    parameter logic [SPR_W-1:0] TAPS    = '0,
    parameter logic [SPR_W-1:0] PRELOAD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              last_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [SPR_W-1:0]  nxt_o
);

    // offset of the fed-back top byte that lands on a remainder bit, or -1
    function automatic int tap_off(input int bit_i);
        int r;
        r = -1;
        for (int d = 0; d < DATA_W; d++) begin
            if (bit_i - d >= 0) begin
                if (TAPS[bit_i - d]) r = d;
            end
        end
        return r;
    endfunction

    logic [SPR_W-1:0]  rem_q;
    logic [DATA_W-1:0] top_q;

    assign top_q = rem_q[SPR_W-1 -: DATA_W];

    for (genvar i = 0; i < SPR_W; i++) begin : g_bit
        localparam int OFF = tap_off(i);
        logic base;
        if (i < DATA_W) begin : g_in
            assign base = data_i[i];
        end else begin : g_sh
            assign base = rem_q[i-DATA_W];
        end
        if (OFF >= 0) begin : g_fb
            assign nxt_o[i] = base ^ top_q[OFF];
        end else begin : g_pass
            assign nxt_o[i] = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rem_q <= PRELOAD;
        else if (acc_i)  rem_q <= last_i ? PRELOAD : nxt_o;
    end

endmodule

// File: rtl/crc2s_fold.sv
module crc2s_fold #(
    parameter int               CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY   = '0,
    parameter int               SPR_W  = 123,
    parameter int               DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SPR_W-1:0] rem_i,
    output logic             fin_o,
    output logic [CRC_W-1:0] crc_o
);

    localparam int STEPS  = (SPR_W + DATA_W - 1) / DATA_W;
    localparam int FOLD_W = STEPS * DATA_W;
    localparam int CNT_W  = $clog2(STEPS + 1);

    function automatic logic [CRC_W-1:0] byte_step(input logic [CRC_W-1:0] c0,
                                                    input logic [DATA_W-1:0] b);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c0;
        for (int k = DATA_W - 1; k >= 0; k--) begin
            fb = c[CRC_W-1] ^ b[k];
            c  = c << 1;
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FOLD_W-1:0] sh_q;
    logic [CRC_W-1:0]  crc_q;

    assign fin_o = busy_q && (cnt_q == CNT_W'(STEPS - 1));
    assign crc_o = crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= '0;
            crc_q  <= '0;
        end else if (load_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            sh_q   <= FOLD_W'(rem_i);
            crc_q  <= '0;
        end else if (busy_q) begin
            crc_q <= byte_step(crc_q, sh_q[FOLD_W-1 -: DATA_W]);
            sh_q  <= sh_q << DATA_W;
            cnt_q <= cnt_q + 1'b1;
            if (fin_o) busy_q <= 1'b0;
        end
    end

    // R6
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && busy_q));

endmodule

// File: rtl/crc32_twostep.sv
module crc32_twostep #(
    parameter int                           DATA_W   = crc2s_pkg::DATA_W,
    parameter int                           CRC_W    = crc2s_pkg::CRC_W,
    parameter logic [crc2s_pkg::CRC_W-1:0]  CRC_POLY = crc2s_pkg::CRC_POLY,
    parameter logic [crc2s_pkg::CRC_W-1:0]  CRC_INIT = crc2s_pkg::CRC_INIT,
    parameter int                           SPR_W    = crc2s_pkg::SPR_W,
    parameter logic [crc2s_pkg::SPR_W-1:0]  SPR_TAPS = crc2s_pkg::SPR_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_done
);

    // multiply by x^-1 modulo G, CRC_W times: x^CRC_W * result == init mod G
    function automatic logic [CRC_W-1:0] unshift_init(input logic [CRC_W-1:0] v0);
        logic [CRC_W-1:0] v;
        v = v0;
        for (int k = 0; k < CRC_W; k++) begin
            if (v[0]) v = ((v ^ CRC_POLY) >> 1) | (CRC_W'(1) << (CRC_W - 1));
            else      v = v >> 1;
        end
        return v;
    endfunction

    localparam logic [CRC_W-1:0] HDR     = unshift_init(CRC_INIT);
    localparam logic [SPR_W-1:0] PRELOAD = SPR_W'(HDR);

    logic             acc;
    logic             close;
    logic             fin;
    logic [SPR_W-1:0] spr_nxt;
    logic [CRC_W-1:0] fold_crc;

    crc2s_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .in_last_i  (in_last),
        .fin_i      (fin),
        .ready_o    (in_ready),
        .done_o     (crc_done),
        .acc_o      (acc),
        .close_o    (close)
    );

    crc2s_sparse_div #(
        .SPR_W   (SPR_W),
        .DATA_W  (DATA_W),
        .TAPS    (SPR_TAPS),
        .PRELOAD (PRELOAD)
    ) u_sparse (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_i  (acc),
        .last_i (in_last),
        .data_i (in_data),
        .nxt_o  (spr_nxt)
    );

    crc2s_fold #(
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .SPR_W  (SPR_W),
        .DATA_W (DATA_W)
    ) u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (close),
        .rem_i  (spr_nxt),
        .fin_o  (fin),
        .crc_o  (fold_crc)
    );

    assign crc_out = ~fold_crc;

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_done && $past(crc_done)) |-> $stable(crc_out));

    // R5
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_done) |-> $past(!in_ready));

endmodule

// File: tb/crc32_twostep_tb_top.sv
`timescale 1ns/1ps
module crc32_twostep_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [31:0] crc_out;
    logic        crc_done;

    always #4 clk = ~clk;

    crc32_twostep dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .crc_out  (crc_out),
        .crc_done (crc_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] msg [0:63];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bit-serial model: all-ones start, MSB first, complemented result
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] r;
        logic fb;
        r = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                fb = r[31] ^ msg[i][b];
                r  = r << 1;
                if (fb) r = r ^ 32'h04C11DB7;
            end
        end
        return ~r;
    endfunction

    // long division remainder of x^r * data by gen
    function automatic int long_rem(input int data, input int dlen, input int gen, input int r);
        int v;
        v = data << r;
        for (int i = dlen + r - 1; i >= r; i--) begin
            if (v[i]) v = v ^ (gen << (i - r));
        end
        return v & ((1 << r) - 1);
    endfunction

    task automatic send_byte(input logic [7:0] d, input logic l);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        while (!in_ready) begin
            @(posedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_msg(input int n, input bit gap, input bit garb,
                           input bit drop, output logic [31:0] got);
        int cyc;
        int low;
        for (int i = 0; i < n; i++) begin
            if (gap && i > 0) begin
                in_valid = 1'b0;
                @(posedge clk);
                #1;
            end
            send_byte(msg[i], i == n - 1);
            if (drop && i == 0) begin
                @(negedge clk);
                chk("R7 done low after next byte taken", {31'd0, crc_done}, 32'd0);
            end
        end
        if (garb) begin
            in_valid = 1'b1;
            in_data  = 8'hA5;
            in_last  = 1'b1;
        end
        cyc = 0;
        low = 0;
        @(negedge clk);
        while (!crc_done && cyc < 64) begin
            if (!in_ready) low++;
            cyc++;
            if (garb && cyc == 16) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk("R5 edges until done", cyc, 32'd16);
        chk("R5 cycles not ready", low, 32'd16);
        got = crc_out;
        chk("R3 crc value", crc_out, ref_crc(n));
    endtask

    task automatic hold_chk(input logic [31:0] got);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 done held", {31'd0, crc_done}, 32'd1);
            chk("R7 crc held", crc_out, got);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL R5 watchdog actual=hang expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] a;
        logic [31:0] b;

        repeat (4) @(negedge clk);
        chk("R1 done in reset", {31'd0, crc_done}, 32'd0);
        chk("R1 ready in reset", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", {31'd0, crc_done}, 32'd0);
        chk("R1 ready after reset", {31'd0, in_ready}, 32'd1);

        // R3 model self-checks: x^3+1 example and the nine-digit string
        chk("R3 model small example", long_rem(4'b1101, 4, 4'b1001, 3), 32'd4);
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        chk("R3 model check string", ref_crc(9), 32'hFC891918);
        run_msg(9, 1'b0, 1'b0, 1'b0, got);
        chk("R3 dut check string", got, 32'hFC891918);
        hold_chk(got);

        // R8 every single-byte message
        for (int v = 0; v < 256; v++) begin
            msg[0] = 8'(v);
            run_msg(1, 1'b0, 1'b0, 1'b0, got);
        end

        // R8 lengths 2..40 with computed patterns
        for (int n = 2; n <= 40; n++) begin
            for (int i = 0; i < n; i++) msg[i] = 8'((n * 37 + i * 101 + i * i) & 255);
            run_msg(n, 1'b0, 1'b0, 1'b0, got);
            if (n <= 4) hold_chk(got);
        end

        // R8 two-byte sweep
        for (int v = 0; v < 64; v++) begin
            msg[0] = 8'(v * 4);
            msg[1] = ~8'(v * 4 + 1);
            run_msg(2, 1'b0, 1'b0, 1'b0, got);
        end

        // R4 leading zeros
        msg[0] = 8'h5A;
        run_msg(1, 1'b0, 1'b0, 1'b0, a);
        msg[0] = 8'h00; msg[1] = 8'h00; msg[2] = 8'h5A;
        run_msg(3, 1'b0, 1'b0, 1'b0, b);
        chk("R4 leading zeros differ", {31'd0, a == b}, 32'd0);
        msg[0] = 8'h00;
        run_msg(1, 1'b0, 1'b0, 1'b0, a);
        msg[0] = 8'h00; msg[1] = 8'h00;
        run_msg(2, 1'b0, 1'b0, 1'b0, b);
        chk("R4 zero messages differ", {31'd0, a == b}, 32'd0);

        // R6 bytes offered during the fold are ignored
        for (int i = 0; i < 7; i++) msg[i] = 8'(8'hC3 ^ 8'(i * 17));
        run_msg(7, 1'b0, 1'b1, 1'b0, got);
        hold_chk(got);
        for (int i = 0; i < 5; i++) msg[i] = 8'(i + 8'h40);
        run_msg(5, 1'b0, 1'b0, 1'b0, got);
        chk("R6 next message unaffected", got, ref_crc(5));

        // R2 idle gaps between bytes
        for (int i = 0; i < 12; i++) msg[i] = 8'(8'h99 + 8'(i * 3));
        run_msg(12, 1'b1, 1'b0, 1'b0, got);
        chk("R2 gaps do not change result", got, ref_crc(12));

        // R7 and R2 back-to-back message started while done is high
        for (int i = 0; i < 6; i++) msg[i] = 8'(8'hF0 - 8'(i * 9));
        run_msg(6, 1'b0, 1'b0, 1'b1, got);
        for (int i = 0; i < 3; i++) msg[i] = 8'(i * 85);
        run_msg(3, 1'b0, 1'b0, 1'b1, got);

        summary();
        $finish;
    end

endmodule